// File: doc/BRIEF.md
# Banked Parallel I/O Controller

This block serves 32 digital lines grouped into four banks of eight, behind a byte-wide register interface. Each bank has a role fixed by a build parameter: absent, input only, output only, or bidirectional. Output-capable banks drive their byte from a written data register. Input-capable banks pass their pins through a synchroniser. The bus can read the synchronised levels; a bidirectional bank returns them inverted.

Each input channel has a two-bit trigger mode. A qualifying edge on the synchronised pin sets a sticky status bit for that channel. A read of the bank's status register returns the bits and clears them. Each bank raises its interrupt request line while any of its status bits is set, and a separate vectored encoder consumes these lines.

Top module: `pio_bank_ctrl`

## Requirements
- R1: Channel n is bit n%8 of bank n/8. Bank b's data register sits at address b (0x0 to 0x3) in a 6-bit address space. Reads of addresses with no register return zero.
- R2: After reset, line_out, bank_irq, bus_rdata, all status bits and all mode registers are zero.
- R3: A write to the data register of an output or bidirectional bank drives that byte on line_out from the next cycle. Writes to input-only or absent banks leave line_out unchanged.
- R4: Reading the data register returns the synchronised pins for an input-only bank, their inverse for a bidirectional bank, and zero for output-only or absent banks. Read data appears on bus_rdata the cycle after the access and holds until the next read.
- R5: A pin passes two synchroniser flops before edge detection. A pin change set up before clock edge k sets status at edge k+2.
- R6: Mode registers sit at 0x10 to 0x17 and read back as written. Register 0x10+k covers channels 4k to 4k+3. Channel 4k+j uses bits [2j+1:2j], coded 00 none, 01 rising, 10 falling, 11 either.
- R7: Status registers sit at 0x8+b. A bit sets on an enabled edge of an input-only or bidirectional channel and stays set otherwise. Edges on output-only or absent banks never set status.
- R8: A status read returns the pre-clear value and clears the bank's bits, except that an edge arriving on the same clock keeps its bit set. Writes to status addresses have no effect.
- R9: bank_irq[b] is high exactly when any status bit of bank b is set.
- R10: Edge polarity refers to the physical pin level, also on bidirectional banks whose readback is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read when bus_sel is high |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| line_in | input | 32 | Raw pin levels of all channels |
| line_out | output | 32 | Driven output levels of all channels |
| bank_irq | output | 4 | Per-bank interrupt request |

## Verification
A wrong synchroniser or edge-detection state shows up on bank_irq one clock from the faulty edge: a missed, early or spurious request, or one with the wrong polarity. A corrupted status or mode register shows up on the next read, either in bus_rdata or in an irq that fails to drop after the clearing read. A wrong output register is visible on line_out the cycle after the write. The reference model therefore compares all three outputs on every clock, so any divergence is caught within one cycle of becoming observable.

// File: rtl/bankio_pkg.sv
package bankio_pkg;

  typedef enum logic [1:0] {
    ROLE_ABSENT = 2'b00,
    ROLE_IN     = 2'b01,
    ROLE_OUT    = 2'b10,
    ROLE_BIDIR  = 2'b11
  } bank_role_e;

  function automatic logic role_senses(bank_role_e r);
    return (r == ROLE_IN) || (r == ROLE_BIDIR);
  endfunction

  function automatic logic role_drives(bank_role_e r);
    return (r == ROLE_OUT) || (r == ROLE_BIDIR);
  endfunction

endpackage

// File: rtl/bankio_sync.sv
module bankio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_prev
);

  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_d;
  logic [W-1:0]             prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = d;
    end else begin : g_next
      assign stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      prev_q  <= '0;
    end else begin
      stage_q <= stage_d;
      prev_q  <= stage_q[STAGES-1];
    end
  end

  assign lvl      = stage_q[STAGES-1];
  assign lvl_prev = prev_q;

endmodule

// File: rtl/bankio_bank.sv
module bankio_bank
  import bankio_pkg::*;
#(
  parameter bank_role_e ROLE = ROLE_IN,
  parameter int         W    = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   lvl,
  input  logic [W-1:0]   lvl_prev,
  input  logic [2*W-1:0] mode,
  input  logic           data_we,
  input  logic [W-1:0]   wdata,
  input  logic           stat_re,
  output logic [W-1:0]   out_q,
  output logic [W-1:0]   rdback,
  output logic [W-1:0]   stat_q,
  output logic           irq
);

  localparam logic SENSES = role_senses(ROLE);
  localparam logic DRIVES = role_drives(ROLE);
  localparam logic INVERT = (ROLE == ROLE_BIDIR);

  logic [W-1:0] rise, fall, hits, stat_d, out_d;

  // edge qualification per channel from its two-bit mode
  always_comb begin
    rise = lvl & ~lvl_prev;
    fall = ~lvl & lvl_prev;
    for (int j = 0; j < W; j++) begin
      hits[j] = SENSES && ((mode[2*j] && rise[j]) || (mode[2*j+1] && fall[j]));
    end
  end

  // next state: a read clears, a fresh edge wins over the clear
  always_comb begin
    stat_d = (stat_re ? '0 : stat_q) | hits;
    out_d  = (DRIVES && data_we) ? wdata : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      out_q  <= '0;
    end else begin
      stat_q <= stat_d;
      out_q  <= out_d;
    end
  end

  assign rdback = INVERT ? ~lvl : (SENSES ? lvl : '0);
  assign irq    = |stat_q;

  // R8
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_re |=> ((stat_q & ~$past(hits)) == '0));

  // R7
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_re && (hits == '0)) |=> $stable(stat_q));

  // R7
  stat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(hits)) == '0));

  // R3
  out_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !DRIVES) |=> $stable(out_q));

endmodule

// File: rtl/pio_bank_ctrl.sv
module pio_bank_ctrl
  import bankio_pkg::*;
#(
  parameter int                    NUM_BANKS   = 4,
  parameter int                    BANK_W      = 8,
  parameter int                    SYNC_STAGES = 2,
  parameter int                    ADDR_W      = 6,
  parameter logic [2*NUM_BANKS-1:0] BANK_ROLES = 8'b00_11_10_01
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [BANK_W-1:0]             bus_wdata,
  output logic [BANK_W-1:0]             bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0]   line_in,
  output logic [NUM_BANKS*BANK_W-1:0]   line_out,
  output logic [NUM_BANKS-1:0]          bank_irq
);

  localparam int NCH           = NUM_BANKS * BANK_W;
  localparam int STAT_BASE     = 8;
  localparam int MASK_BASE     = 16;
  localparam int MASK_PER_BANK = 2;
  localparam int NUM_MASK      = NUM_BANKS * MASK_PER_BANK;

  logic rd_en, wr_en;
  assign rd_en = bus_sel & ~bus_wr;
  assign wr_en = bus_sel & bus_wr;

  logic [NCH-1:0] lvl, lvl_prev;

  bankio_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .d        (line_in),
    .lvl      (lvl),
    .lvl_prev (lvl_prev)
  );

  // trigger-mode registers
  logic [NUM_MASK-1:0][BANK_W-1:0] mask_q, mask_d;
  logic [NUM_MASK-1:0]             mask_sel;

  always_comb begin
    for (int m = 0; m < NUM_MASK; m++) begin
      mask_sel[m] = (bus_addr == ADDR_W'(MASK_BASE + m));
      mask_d[m]   = (wr_en && mask_sel[m]) ? bus_wdata : mask_q[m];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  // banks
  logic [NUM_BANKS-1:0]             data_sel, stat_sel;
  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_rdback, bank_stat;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam bank_role_e ROLE_B = bank_role_e'(BANK_ROLES[2*b +: 2]);

    assign data_sel[b] = (bus_addr == ADDR_W'(b));
    assign stat_sel[b] = (bus_addr == ADDR_W'(STAT_BASE + b));

    bankio_bank #(.ROLE(ROLE_B), .W(BANK_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl[b*BANK_W +: BANK_W]),
      .lvl_prev (lvl_prev[b*BANK_W +: BANK_W]),
      .mode     ({mask_q[MASK_PER_BANK*b+1], mask_q[MASK_PER_BANK*b]}),
      .data_we  (wr_en & data_sel[b]),
      .wdata    (bus_wdata),
      .stat_re  (rd_en & stat_sel[b]),
      .out_q    (line_out[b*BANK_W +: BANK_W]),
      .rdback   (bank_rdback[b]),
      .stat_q   (bank_stat[b]),
      .irq      (bank_irq[b])
    );

    if (!role_senses(ROLE_B)) begin : g_nosense_chk
      // R4
      blind_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && data_sel[b]) |=> (bus_rdata == '0));
    end
  end

  // read path
  logic [BANK_W-1:0] rd_val, rdata_d, rdata_q;
  logic              any_sel;

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      rd_val |= data_sel[b] ? bank_rdback[b] : '0;
      rd_val |= stat_sel[b] ? bank_stat[b]   : '0;
    end
    for (int m = 0; m < NUM_MASK; m++) begin
      rd_val |= mask_sel[m] ? mask_q[m] : '0;
    end
    rdata_d = rd_en ? rd_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign any_sel   = (|data_sel) | (|stat_sel) | (|mask_sel);

  // R1
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !any_sel) |=> (bus_rdata == '0));

  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(bus_rdata));

endmodule

// File: tb/test_pio_bank_ctrl.sv
module test_pio_bank_ctrl;

  localparam logic [7:0] ROLES = 8'b00_11_10_01; // b0 in, b1 out, b2 bidir, b3 absent

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [5:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [31:0] line_in, line_out;
  logic [3:0]  bank_irq;

  always #10 clk = ~clk; // 50 MHz

  pio_bank_ctrl #(.BANK_ROLES(ROLES)) i_pio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .line_in(line_in), .line_out(line_out), .bank_irq(bank_irq)
  );

  int  nchk = 0;
  int  nfail = 0;
  bit  done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_s1, m_s2, m_prev, m_out, m_stat, m_hit;
  bit [7:0]  m_mask [8];
  bit [7:0]  m_rd;

  function automatic int role(int b);
    return int'((ROLES >> (2 * b)) & 8'd3);
  endfunction

  function automatic bit [7:0] mread(int a);
    if (a < 4) begin
      if (role(a) == 1) return m_s2[8*a +: 8];
      if (role(a) == 3) return ~m_s2[8*a +: 8];
      return 8'h00;
    end
    if (a >= 8 && a < 12)  return m_stat[8*(a-8) +: 8];
    if (a >= 16 && a < 24) return m_mask[a-16];
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_out = 0; m_stat = 0; m_rd = 0;
      for (int i = 0; i < 8; i++) m_mask[i] = 0;
    end else begin
      for (int ch = 0; ch < 32; ch++) begin
        int md;
        bit up, dn, sens;
        md   = int'((m_mask[ch/4] >> (2 * (ch % 4))) & 8'd3);
        up   = m_s2[ch] && !m_prev[ch];
        dn   = !m_s2[ch] && m_prev[ch];
        sens = (role(ch/8) == 1) || (role(ch/8) == 3);
        m_hit[ch] = sens && ((md[0] && up) || (md[1] && dn));
      end
      if (bus_sel && !bus_wr) begin
        m_rd = mread(int'(bus_addr));
        if (bus_addr >= 8 && bus_addr < 12) m_stat[8*(int'(bus_addr)-8) +: 8] = 8'h00;
      end
      m_stat = m_stat | m_hit;
      if (bus_sel && bus_wr) begin
        if (bus_addr < 4 && role(int'(bus_addr)) >= 2) m_out[8*int'(bus_addr) +: 8] = bus_wdata;
        if (bus_addr >= 16 && bus_addr < 24) m_mask[int'(bus_addr)-16] = bus_wdata;
      end
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = line_in;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [3:0] ei;
      for (int b = 0; b < 4; b++) ei[b] = (m_stat[8*b +: 8] != 0);
      chk(line_out == m_out, "R3 line_out vs model", line_out, m_out);
      chk(bank_irq == ei, "R9 bank_irq vs model", {28'h0, bank_irq}, {28'h0, ei});
      chk(bus_rdata == m_rd, "R4 bus_rdata vs model", {24'h0, bus_rdata}, {24'h0, m_rd});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bwrite(input logic [5:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    @(negedge clk);
  endtask

  task automatic bread(input logic [5:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  logic [7:0] rv;

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; line_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    chk(line_out == 0, "R2 line_out after reset", line_out, 0);
    chk(bank_irq == 0, "R2 bank_irq after reset", {28'h0, bank_irq}, 0);
    chk(bus_rdata == 0, "R2 bus_rdata after reset", {24'h0, bus_rdata}, 0);
    bread(6'h10, rv); chk(rv == 0, "R2 mode register after reset", {24'h0, rv}, 0);

    bwrite(6'h01, 8'hA5);
    chk(line_out[15:8] == 8'hA5, "R3 output bank drives", {24'h0, line_out[15:8]}, 32'hA5);
    bwrite(6'h00, 8'hFF);
    chk(line_out[7:0] == 8'h00, "R3 input bank write ignored", {24'h0, line_out[7:0]}, 0);
    bwrite(6'h03, 8'hFF);
    chk(line_out[31:24] == 8'h00, "R3 absent bank write ignored", {24'h0, line_out[31:24]}, 0);
    bwrite(6'h02, 8'h20);
    chk(line_out[21] == 1'b1, "R1 channel 21 is bank 2 bit 5", {31'h0, line_out[21]}, 1);

    line_in[7:0] = 8'h3C; line_in[23:16] = 8'h0F;
    settle();
    chk(bank_irq == 0, "R6 mode none sets nothing", {28'h0, bank_irq}, 0);
    bread(6'h00, rv); chk(rv == 8'h3C, "R4 input bank readback", {24'h0, rv}, 32'h3C);
    bread(6'h02, rv); chk(rv == 8'hF0, "R4 bidir readback inverted", {24'h0, rv}, 32'hF0);
    bread(6'h01, rv); chk(rv == 8'h00, "R4 output bank reads zero", {24'h0, rv}, 0);
    bread(6'h03, rv); chk(rv == 8'h00, "R4 absent bank reads zero", {24'h0, rv}, 0);
    bread(6'h30, rv); chk(rv == 8'h00, "R1 unmapped reads zero", {24'h0, rv}, 0);
    bread(6'h05, rv); chk(rv == 8'h00, "R1 gap address reads zero", {24'h0, rv}, 0);

    // ch0 either, ch1 falling, ch2 rising, ch3 none
    bwrite(6'h10, 8'h1B);
    bread(6'h10, rv); chk(rv == 8'h1B, "R6 mode readback", {24'h0, rv}, 32'h1B);

    line_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(bank_irq[0] == 1'b0, "R5 not yet after two edges", {31'h0, bank_irq[0]}, 0);
    @(negedge clk);
    chk(bank_irq[0] == 1'b1, "R5 set at third edge", {31'h0, bank_irq[0]}, 1);
    bread(6'h08, rv); chk(rv == 8'h01, "R7 status ch0 either edge", {24'h0, rv}, 1);
    chk(bank_irq[0] == 1'b0, "R8 read clears", {31'h0, bank_irq[0]}, 0);

    line_in[3] = 1'b0; settle();
    chk(bank_irq[0] == 1'b0, "R6 none on ch3", {31'h0, bank_irq[0]}, 0);
    line_in[2] = 1'b0; settle();
    chk(bank_irq[0] == 1'b0, "R6 rising-only ignores fall", {31'h0, bank_irq[0]}, 0);
    line_in[1] = 1'b1; settle();
    chk(bank_irq[0] == 1'b0, "R6 falling-only ignores rise", {31'h0, bank_irq[0]}, 0);
    line_in[1] = 1'b0; settle();
    bread(6'h08, rv); chk(rv == 8'h02, "R6 falling edge on ch1", {24'h0, rv}, 2);

    // edge lands in the same clock as the clearing read
    line_in[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 6'h08;
    @(negedge clk);
    bus_sel = 0;
    chk(bus_rdata == 8'h00, "R8 read returns pre-edge value", {24'h0, bus_rdata}, 0);
    chk(bank_irq[0] == 1'b1, "R8 simultaneous edge wins", {31'h0, bank_irq[0]}, 1);
    bwrite(6'h08, 8'h00);
    chk(bank_irq[0] == 1'b1, "R8 status write ignored", {31'h0, bank_irq[0]}, 1);
    bread(6'h08, rv); chk(rv == 8'h04, "R8 kept bit reads back", {24'h0, rv}, 4);

    // bidir bank: rising refers to the pin, not the inverted readback
    bwrite(6'h14, 8'h01);
    line_in[16] = 1'b0; settle();
    chk(bank_irq[2] == 1'b0, "R10 pin fall ignored by rising mode", {31'h0, bank_irq[2]}, 0);
    line_in[16] = 1'b1; settle();
    chk(bank_irq[2] == 1'b1, "R10 pin rise sets on bidir", {31'h0, bank_irq[2]}, 1);
    bread(6'h0A, rv); chk(rv == 8'h01, "R7 bidir status", {24'h0, rv}, 1);

    bwrite(6'h12, 8'hFF); bwrite(6'h13, 8'hFF);
    bwrite(6'h16, 8'hFF); bwrite(6'h17, 8'hFF);
    line_in[15:8] = 8'hFF; line_in[31:24] = 8'hFF; settle();
    line_in[15:8] = 8'h00; line_in[31:24] = 8'h00; settle();
    chk(bank_irq[1] == 1'b0, "R7 output bank never sets", {31'h0, bank_irq[1]}, 0);
    chk(bank_irq[3] == 1'b0, "R7 absent bank never sets", {31'h0, bank_irq[3]}, 0);
    bread(6'h0B, rv); chk(rv == 8'h00, "R7 absent status zero", {24'h0, rv}, 0);

    // mixed traffic, compared against the model every clock
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      line_in  = (r[3:0] == 0) ? $urandom : line_in ^ (32'h1 << r[8:4]);
      bus_sel  = r[9] | r[10];
      bus_wr   = r[11];
      bus_addr = r[12] ? {1'b0, r[16:13] < 4'd8 ? 2'b01 : 2'b10, r[15:13]} : r[18:13];
      bus_wdata = r[26:19];
      @(negedge clk);
    end
    bus_sel = 0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule